// File: doc/BRIEF.md
# Encoder timer counter

A single up/down counter with a small register interface that advances from one of several sources chosen by a slave-mode field. The sources are: every clock cycle; one phase of a two-phase encoder pair, with the other phase's level giving the direction; both phases decoded as full quadrature, with four counts per encoder cycle; or the clock while an internal trigger pulse reloads the counter. The counter wraps between zero and an auto-reload limit. Each wrap is an update event and produces a one-cycle pulse on an output pin.

The limit register can be double-buffered. With preload on, software writes land in a shadow copy that becomes active only at the next update event, so a running period is never cut short. Software can read or overwrite the live count at any time. In the encoder modes the direction bit is driven by the decoder and reads back the last decoded direction.

Top module: `enc_timer`

## Requirements
- R1: After reset the control and slave-mode registers read 0, the counter reads 0, the limit register reads all ones (0xFFFF) and the update output is low.
- R2: Registers sit at control 0x00 (bit 0 enable, bit 4 direction with 1 meaning down, bit 7 preload enable), slave mode 0x08 (bits 2:0), counter 0x24 and limit 0x2C. Unmapped addresses read 0. A counter write takes effect at the next edge and overrides counting in that cycle.
- R3: Slave mode 0 and modes 5 to 7 count once per clock while enabled, in the direction given by the direction bit. With enable cleared the counter holds.
- R4: Counting up, a step from the active limit goes to 0 and raises the update output for exactly that one cycle.
- R5: Counting down, a step from 0 goes to the active limit and raises the update output for that cycle.
- R6: Slave mode 1 counts on each edge of input A alone. The step is up when, after the edge, A differs from B, and down otherwise.
- R7: Slave mode 2 counts on each edge of input B alone. The step is up when, after the edge, B equals A, and down otherwise.
- R8: Slave mode 3 counts every single-input edge of A or B, giving four counts per encoder cycle. The sequence AB = 00, 10, 11, 01 counts up.
- R9: An encoder sample in which A and B both changed produces no count.
- R10: In slave modes 1 to 3, writes to the direction bit are ignored, and the bit reads back the direction of the last counted encoder edge (1 = down).
- R11: With preload enabled, a limit write is visible on readback but the active limit changes only at the next update event. With preload disabled it changes at once.
- R12: In slave mode 4 the counter runs from the clock, and a rising edge on the trigger input while enabled reloads it to 0 (counting up) or to the active limit (counting down). In other modes the trigger has no effect.
- R13: Encoder inputs pass through a two-stage synchronizer, and a single input change is counted within four clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write byte address |
| wr_data_i | input | DATA_W | Write data |
| rd_addr_i | input | ADDR_W | Read byte address |
| rd_data_o | output | DATA_W | Read data, combinational from rd_addr_i |
| enc_a_i | input | 1 | Encoder phase A, asynchronous |
| enc_b_i | input | 1 | Encoder phase B, asynchronous |
| trig_i | input | 1 | Internal trigger, synchronous to clk_i |
| upd_o | output | 1 | One-cycle update event pulse |

## Verification
A corrupted direction or a mis-decoded encoder edge shows up in the counter readback within one sampled input change. The bench reads the count after every randomized encoder move and compares it against a gray-code position model, so such an error is caught on the move that causes it. A wrong active limit, for example a preload transfer taken early, is hidden until the next wrap. It then appears as a count off by the difference in limits, and as an update pulse in the wrong window. Each wrap scenario is therefore run far enough to cross the limit.

// File: rtl/enc_timer.sv
`timescale 1ns/1ps
module enc_timer #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              enc_a_i,
  input  logic              enc_b_i,
  input  logic              trig_i,
  output logic              upd_o
);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_SMODE = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_CNT   = ADDR_W'(8'h24);
  localparam logic [ADDR_W-1:0] A_ARR   = ADDR_W'(8'h2C);
  localparam logic [CNT_W-1:0]  CNT_ONE = CNT_W'(1);

  logic             en_q, dir_q, arpe_q, upd_q, trig_d;
  logic [2:0]       smode_q;
  logic [CNT_W-1:0] cnt_q, arr_pre_q, arr_act_q, arr_next, cnt_next;
  logic [1:0]       a_sync, b_sync;
  logic             a_d, b_d;

  wire wr_ctrl  = wr_en_i && (wr_addr_i == A_CTRL);
  wire wr_smode = wr_en_i && (wr_addr_i == A_SMODE);
  wire wr_cnt   = wr_en_i && (wr_addr_i == A_CNT);
  wire wr_arr   = wr_en_i && (wr_addr_i == A_ARR);
  wire [CNT_W-1:0] wval = wr_data_i[CNT_W-1:0];
  wire unused_hi = ^wr_data_i[DATA_W-1:CNT_W];

  wire a_s   = a_sync[1];
  wire b_s   = b_sync[1];
  wire a_chg = a_s ^ a_d;
  wire b_chg = b_s ^ b_d;

  wire enc_mode = (smode_q == 3'd1) || (smode_q == 3'd2) || (smode_q == 3'd3);
  wire rst_mode = (smode_q == 3'd4);

  logic step, up;
  always_comb begin
    case (smode_q)
      3'd1:    begin step = a_chg & ~b_chg; up = a_s ^ b_s; end
      3'd2:    begin step = b_chg & ~a_chg; up = ~(a_s ^ b_s); end
      3'd3:    begin step = a_chg ^ b_chg;  up = a_chg ? (a_s ^ b_s) : ~(a_s ^ b_s); end
      default: begin step = 1'b1;           up = ~dir_q; end
    endcase
  end

  wire reload  = en_q && rst_mode && trig_i && !trig_d;
  wire tick    = en_q && step && !wr_cnt && !reload;
  wire at_top  = (cnt_q == arr_act_q);
  wire at_zero = (cnt_q == '0);
  wire uev     = tick && (up ? at_top : at_zero);

  always_comb begin
    if (wr_arr && !arpe_q)     arr_next = wval;
    else if (uev && arpe_q)    arr_next = arr_pre_q;
    else                       arr_next = arr_act_q;
  end

  always_comb begin
    if (wr_cnt)       cnt_next = wval;
    else if (reload)  cnt_next = dir_q ? arr_act_q : '0;
    else if (tick) begin
      if (up)         cnt_next = at_top  ? '0       : cnt_q + CNT_ONE;
      else            cnt_next = at_zero ? arr_next : cnt_q - CNT_ONE;
    end
    else              cnt_next = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_sync <= '0;
      b_sync <= '0;
      a_d    <= 1'b0;
      b_d    <= 1'b0;
      trig_d <= 1'b0;
    end else begin
      a_sync <= {a_sync[0], enc_a_i};
      b_sync <= {b_sync[0], enc_b_i};
      a_d    <= a_s;
      b_d    <= b_s;
      trig_d <= trig_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= 1'b0;
      dir_q     <= 1'b0;
      arpe_q    <= 1'b0;
      smode_q   <= '0;
      cnt_q     <= '0;
      arr_pre_q <= '1;
      arr_act_q <= '1;
      upd_q     <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en_q   <= wr_data_i[0];
        arpe_q <= wr_data_i[7];
      end
      if (enc_mode) begin
        if (tick) dir_q <= ~up;
      end else if (wr_ctrl) begin
        dir_q <= wr_data_i[4];
      end
      if (wr_smode) smode_q   <= wr_data_i[2:0];
      if (wr_arr)   arr_pre_q <= wval;
      arr_act_q <= arr_next;
      cnt_q     <= cnt_next;
      upd_q     <= uev;
    end
  end

  assign upd_o = upd_q;

  always_comb begin
    case (rd_addr_i)
      A_CTRL:  rd_data_o = DATA_W'({arpe_q, 2'b00, dir_q, 3'b000, en_q});
      A_SMODE: rd_data_o = DATA_W'(smode_q);
      A_CNT:   rd_data_o = DATA_W'(cnt_q);
      A_ARR:   rd_data_o = DATA_W'(arr_pre_q);
      default: rd_data_o = '0;
    endcase
  end

  assert_sw_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cnt |=> cnt_q == $past(wval));

  assert_hold_when_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !wr_cnt) |=> $stable(cnt_q));

  assert_upd_at_limit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |-> (cnt_q == '0 || cnt_q == arr_act_q));

  assert_invalid_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enc_mode && a_chg && b_chg && !wr_cnt) |=> $stable(cnt_q));

  assert_dir_readonly_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enc_mode && !tick) |=> $stable(dir_q));

  assert_preload_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arpe_q && !uev) |=> $stable(arr_act_q));

  assert_trig_reload_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reload && !wr_cnt) |=> cnt_q == ($past(dir_q) ? $past(arr_act_q) : '0));
endmodule

// File: tb/enc_timer_tb.sv
`timescale 1ns/1ps
module enc_timer_tb_top;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam logic [AW-1:0] CTRL = 8'h00, SMODE = 8'h08, CNT = 8'h24, ARR = 8'h2C;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0, rd_data;
  logic enc_a = 1'b0, enc_b = 1'b0, trig = 1'b0, upd;
  int checks = 0, errors = 0, upd_seen = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  enc_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .enc_a_i(enc_a), .enc_b_i(enc_b), .trig_i(trig), .upd_o(upd));

  always @(negedge clk) if (rst_n && upd) upd_seen++;

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic run(input logic [DW-1:0] ctrl, input int n);
    wr(CTRL, ctrl | 32'h1);
    repeat (n - 1) @(negedge clk);
    wr(CTRL, ctrl & ~32'h1);
  endtask

  function automatic int gpos(bit a, bit b);
    case ({a, b})
      2'b00: return 0;
      2'b10: return 1;
      2'b11: return 2;
      default: return 3;
    endcase
  endfunction

  function automatic int step_model(int v, bit up, int lim);
    if (up) return (v == lim) ? 0 : v + 1;
    return (v == 0) ? lim : v - 1;
  endfunction

  logic [DW-1:0] d;

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(CTRL, d);  check("R1 ctrl", d, 0);
    rd(SMODE, d); check("R1 smode", d, 0);
    rd(CNT, d);   check("R1 cnt", d, 0);
    rd(ARR, d);   check("R1 arr", d, 32'hFFFF);
    check("R1 upd", {31'b0, upd}, 0);

    wr(CNT, 32'h1234);  rd(CNT, d);   check("R2 cnt write", d, 32'h1234);
    wr(SMODE, 32'h3);   rd(SMODE, d); check("R2 smode", d, 3);
    rd(8'h10, d);       check("R2 unmapped", d, 0);
    wr(SMODE, 0);

    wr(ARR, 100); wr(CNT, 5);
    run(0, 7); rd(CNT, d); check("R3 internal count", d, 12);
    repeat (5) @(negedge clk); rd(CNT, d); check("R3 hold disabled", d, 12);
    wr(SMODE, 6); run(0, 3); rd(CNT, d); check("R3 mode6 clock", d, 15);
    wr(SMODE, 0);

    wr(ARR, 10); wr(CNT, 8); upd_seen = 0;
    run(0, 4); rd(CNT, d); check("R4 up wrap", d, 1);
    check("R4 one pulse", upd_seen, 1);
    wr(CNT, 1); upd_seen = 0;
    run(32'h10, 3); rd(CNT, d); check("R5 down wrap", d, 9);
    check("R5 one pulse", upd_seen, 1);

    wr(CTRL, 32'h80); wr(ARR, 4);
    rd(ARR, d); check("R11 shadow readback", d, 4);
    wr(CNT, 0); run(32'h80, 6); rd(CNT, d); check("R11 old limit active", d, 6);
    wr(CNT, 9); run(32'h80, 3); rd(CNT, d); check("R11 wrap at old limit", d, 1);
    run(32'h80, 4); rd(CNT, d); check("R11 new limit after update", d, 0);
    wr(CTRL, 0); wr(ARR, 3); wr(CNT, 0);
    run(0, 5); rd(CNT, d); check("R11 immediate limit", d, 1);

    wr(ARR, 100); wr(SMODE, 4);
    for (int pass = 0; pass < 3; pass++) begin
      logic [DW-1:0] c;
      c = (pass == 1) ? 32'h10 : 32'h0;
      if (pass == 2) wr(SMODE, 0);
      wr(CNT, 50);
      wr(CTRL, c | 1);
      repeat (3) @(negedge clk);
      trig = 1'b1; @(negedge clk); trig = 1'b0;
      wr(CTRL, c);
      rd(CNT, d);
      if (pass == 0) check("R12 reload up", d, 1);
      else if (pass == 1) check("R12 reload down", d, 99);
      else check("R12 trigger ignored", d, 55);
    end

    wr(ARR, 12);
    for (int m = 1; m <= 3; m++) begin
      int expc, expd;
      bit na, nb;
      wr(SMODE, 0); wr(CTRL, 0); wr(CNT, 6);
      wr(SMODE, m); wr(CTRL, 32'h11);
      expc = 6; expd = 0;
      rd(CTRL, d); check("R10 dir write ignored", {31'b0, d[4]}, 0);
      for (int k = 0; k < 30; k++) begin
        int r, dl;
        bit ca, cb, counted, up;
        r = $urandom % 8;
        na = enc_a; nb = enc_b;
        if (r == 0 || (k == 3 && m == 3)) begin na = ~na; nb = ~nb; end
        else if (r[0]) na = ~na;
        else nb = ~nb;
        ca = (na != enc_a); cb = (nb != enc_b);
        dl = (gpos(na, nb) - gpos(enc_a, enc_b) + 4) % 4;
        up = (dl == 1);
        counted = !(ca && cb) &&
                  ((m == 1 && ca) || (m == 2 && cb) || (m == 3 && (ca || cb)));
        if (counted) begin expc = step_model(expc, up, 12); expd = up ? 0 : 1; end
        enc_a = na; enc_b = nb;
        repeat (4) @(negedge clk);
        rd(CNT, d);
        if (ca && cb) check("R9 invalid move", d, expc);
        else if (m == 1) check("R6 channel A count", d, expc);
        else if (m == 2) check("R7 channel B count", d, expc);
        else check("R8 quadrature count R13", d, expc);
        rd(CTRL, d); check("R10 decoded dir", {31'b0, d[4]}, expd);
      end
    end

    wr(CTRL, 0); wr(SMODE, 3); wr(CNT, 0); wr(CTRL, 1);
    enc_a = 0; enc_b = 0; repeat (4) @(negedge clk);
    wr(CNT, 0);
    for (int s = 0; s < 4; s++) begin
      if (s == 0) enc_a = 1; else if (s == 1) enc_b = 1;
      else if (s == 2) enc_a = 0; else enc_b = 0;
      repeat (4) @(negedge clk);
    end
    rd(CNT, d); check("R8 four counts per cycle", d, 4);
    wr(CTRL, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule